// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial core of an SPI master. It accepts parallel words through a valid/ready transmit port and shifts each word out on the serial data output. It generates the serial clock and samples the serial data input into a receive word. When a word is complete, the receive word is pushed out through a one-cycle valid strobe toward a receive FIFO. That FIFO must always accept the word.

Every setting comes from static configuration inputs:

- the divider reload value;
- the word length, given as bits minus one;
- clock polarity, and a phase bit whose sense is the inverse of the usual CPHA;
- an idle line level;
- bit order;
- internal loopback;
- separate transmitter and receiver disables.

These inputs are captured only when a word starts from idle. While the engine is busy, the surrounding logic may reprogram them freely.

A transmit handshake always starts a word, even when the transmitter is switched off. In that case the data is ignored, and the handshake serves only as a request to clock in one received word. The busy output covers the whole of the final word, so a controller can tell when the line has really gone quiet after its FIFO has drained.

Top module: `spi_eng_core`

## Requirements
- R1: While a word is shifting, each half period of `sclk` lasts exactly `cfg_div`+1 clock cycles. `sclk` equals the captured polarity during even half periods and its inverse during odd ones, so one bit takes 2*(`cfg_div`+1) cycles.
- R2: The word length is `cfg_len_m1`+1 bits, and a field value of 0 is treated as 2 bits. Bits of `tx_data` above the word length are ignored. `rx_data` carries the received bits right-aligned, with all higher bits zero.
- R3: With `cfg_ph`=1, the first data bit is on `mosi` from the first cycle of the word. Input is sampled at the end of each even half period, and `mosi` changes at the end of each odd one. With `cfg_ph`=0, input is sampled at the end of odd half periods, and `mosi` moves to the next bit at the end of even half periods after the first.
- R4: `cfg_msb`=1 sends bit N-1 of the word first and places the first received bit at bit N-1. `cfg_msb`=0 sends bit 0 first and places the first received bit at bit 0.
- R5: With `cfg_loop`=1, the receiver samples the engine's own serial output instead of `miso`, so the received word equals the sent word.
- R6: With `cfg_tx_off`=1, `mosi` holds the captured idle level for the whole word, whatever `tx_data` holds.
- R7: With `cfg_rx_off`=1, no `rx_valid` strobe is produced for the word.
- R8: `busy` rises in the cycle after a word is accepted from idle. It stays high until the last half period of the last word has ended. `rx_valid` pulses for one cycle right after each word's last half period.
- R9: `tx_ready` is high while idle and in the final cycle of a word. A word accepted in that final cycle starts at once, with no idle cycle and no drop of `busy`.
- R10: Configuration inputs are captured only when a word is accepted from idle. Changes made while `busy` is high do not affect the current word or any back-to-back words that follow it.
- R11: While idle, `sclk` follows `cfg_pol` and `mosi` follows `cfg_idle`.
- R12: After reset, `busy` and `rx_valid` are low, `tx_ready` is high and `rx_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | 16 | Divider reload value; the half period is this value + 1 cycles |
| cfg_len_m1 | input | 5 | Word length minus one |
| cfg_pol | input | 1 | Clock polarity (idle level of sclk) |
| cfg_ph | input | 1 | 1: sample on leading edge; 0: sample on trailing edge |
| cfg_idle | input | 1 | Idle level of mosi; also driven while the transmitter is off |
| cfg_msb | input | 1 | 1: MSB first; 0: LSB first |
| cfg_loop | input | 1 | Internal loopback of mosi to the receiver |
| cfg_tx_off | input | 1 | Transmitter disable |
| cfg_rx_off | input | 1 | Receiver disable |
| tx_valid | input | 1 | Transmit word available |
| tx_data | input | 32 | Transmit word, right-aligned |
| tx_ready | output | 1 | Engine takes the word this cycle |
| rx_valid | output | 1 | One-cycle strobe: received word ready |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is shifting |

## Verification
The hardest situation to reach is a configuration change in the middle of a chain of back-to-back words. The engine must keep the settings captured at the first word across every later word that starts without an idle gap. To get there, the stimulus queues three words at once so that `tx_valid` is already high in each word's final cycle. It then rewrites the divider, length and mode inputs while `busy` is high. The cycle-level reference model in the bench keeps its own captured settings and flags any cycle in which the clock or data deviates.

// File: rtl/spi_eng_pkg.sv
// Shared types for the SPI master shift engine.
package spi_eng_pkg;

    // Mode flags captured together at the start of a word.
    typedef struct packed {
        logic pol;      // serial clock idle level
        logic ph;       // 1: sample on leading edge, 0: on trailing edge
        logic idle;     // data line idle level
        logic msb;      // 1: most significant bit first
        logic loop;     // receiver listens to own output
        logic tx_off;   // transmitter disabled
        logic rx_off;   // receiver disabled
    } mode_t;

endpackage

// File: rtl/spi_eng_baud.sv
// Half-period tick generator.
// Counts module clocks while run is high and pulses tick every div+1 cycles.
// Assumes div is stable while run is high.
module spi_eng_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count up to the reload value, restart on tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (!run || tick)    cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_eng_txsh.sv
// Transmit shift register.
// Loads a word and presents one bit at a time in the selected order.
// Assumes nbits lies in 2..WORD_W when load is high.
module spi_eng_txsh #(
    parameter int WORD_W = 32,
    parameter int NB_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] data,
    input  logic [NB_W-1:0]   nbits,
    input  logic              msb,
    input  logic              shift,
    output logic              bit_out
);
    logic [WORD_W-1:0] sh;
    logic              msb_q;

    assign bit_out = msb_q ? sh[WORD_W-1] : sh[0];

    // Load left-justified for MSB-first, as is for LSB-first; then shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            msb_q <= 1'b1;
        end else if (load) begin
            msb_q <= msb;
            sh    <= msb ? (data << (WORD_W - int'(nbits))) : data;
        end else if (shift) begin
            sh    <= msb_q ? {sh[WORD_W-2:0], 1'b0} : {1'b0, sh[WORD_W-1:1]};
        end
    end
endmodule

// File: rtl/spi_eng_rxsh.sv
// Receive shift register.
// Gathers sampled bits and presents the word right-aligned, including a
// sample taken in the current cycle. Assumes clear at every word start.
module spi_eng_rxsh #(
    parameter int WORD_W = 32,
    parameter int NB_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              bit_in,
    input  logic              msb,
    input  logic [NB_W-1:0]   nbits,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] sh_nxt;

    // Next contents: MSB-first enters at bit 0, LSB-first enters at the top.
    always_comb begin
        sh_nxt = sh;
        if (sample) sh_nxt = msb ? {sh[WORD_W-2:0], bit_in} : {bit_in, sh[WORD_W-1:1]};
        word = msb ? sh_nxt : (sh_nxt >> (WORD_W - int'(nbits)));
    end

    // Hold gathered bits; a word start clears them.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) sh <= '0;
        else                 sh <= sh_nxt;
    end
endmodule

// File: rtl/spi_eng_core.sv
// SPI master shift engine, top level.
// Takes words on a valid/ready port, shifts them out with a divided serial
// clock and pushes received words with a one-cycle strobe. Settings are
// captured when a word starts from idle. Assumes the receive side always
// accepts rx_valid.
module spi_eng_core
    import spi_eng_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int LEN_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIV_W-1:0]      cfg_div,
    input  logic [LEN_W-1:0]      cfg_len_m1,
    input  logic                  cfg_pol,
    input  logic                  cfg_ph,
    input  logic                  cfg_idle,
    input  logic                  cfg_msb,
    input  logic                  cfg_loop,
    input  logic                  cfg_tx_off,
    input  logic                  cfg_rx_off,
    input  logic                  tx_valid,
    input  logic [(1<<LEN_W)-1:0] tx_data,
    output logic                  tx_ready,
    output logic                  rx_valid,
    output logic [(1<<LEN_W)-1:0] rx_data,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso,
    output logic                  busy
);
    localparam int WORD_W = 1 << LEN_W;
    localparam int NB_W   = LEN_W + 1;
    localparam int HALF_W = LEN_W + 2;

    mode_t             mode_in, mode_q, mode_sel;
    logic [NB_W-1:0]   nbits_in, nbits_q, nbits_sel;
    logic [DIV_W-1:0]  div_q;
    logic              active;
    logic [HALF_W-1:0] half_cnt;
    logic [HALF_W-1:0] last_half;
    logic              tick, last_tick, accept;
    logic              samp_en, shift_en;
    logic              tx_bit, line_out, rx_bit;
    logic [WORD_W-1:0] rx_word;

    // Gather the live mode inputs and clamp the word length to at least 2.
    always_comb begin
        mode_in  = '{pol: cfg_pol, ph: cfg_ph, idle: cfg_idle, msb: cfg_msb,
                     loop: cfg_loop, tx_off: cfg_tx_off, rx_off: cfg_rx_off};
        nbits_in = (cfg_len_m1 == '0) ? NB_W'(2) : (NB_W'(cfg_len_m1) + NB_W'(1));
        mode_sel  = active ? mode_q  : mode_in;
        nbits_sel = active ? nbits_q : nbits_in;
    end

    assign last_half = {nbits_q, 1'b0} - HALF_W'(1);
    assign last_tick = tick && (half_cnt == last_half);
    assign tx_ready  = !active || last_tick;
    assign accept    = tx_valid && tx_ready;

    // Leading edges end even half periods, trailing edges end odd ones.
    assign samp_en  = tick && (mode_q.ph ? !half_cnt[0] : half_cnt[0]);
    assign shift_en = tick && !last_tick &&
                      (mode_q.ph ? half_cnt[0] : (!half_cnt[0] && half_cnt != '0));

    assign line_out = mode_q.tx_off ? mode_q.idle : tx_bit;
    assign rx_bit   = mode_q.loop ? line_out : miso;
    assign mosi     = active ? line_out : cfg_idle;
    assign sclk     = active ? (mode_q.pol ^ half_cnt[0]) : cfg_pol;
    assign busy     = active;

    // Capture settings only when a word starts from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            nbits_q <= NB_W'(2);
            div_q   <= '0;
        end else if (accept && !active) begin
            mode_q  <= mode_in;
            nbits_q <= nbits_in;
            div_q   <= cfg_div;
        end
    end

    // Word sequencing: start on accept, count half periods, stop after last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            half_cnt <= '0;
        end else if (accept) begin
            active   <= 1'b1;
            half_cnt <= '0;
        end else begin
            if (last_tick) active <= 1'b0;
            if (tick)      half_cnt <= half_cnt + 1'b1;
        end
    end

    // Push the received word right after the final half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= last_tick && !mode_q.rx_off;
            if (last_tick && !mode_q.rx_off) rx_data <= rx_word;
        end
    end

    spi_eng_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(active), .div(div_q), .tick(tick)
    );

    spi_eng_txsh #(.WORD_W(WORD_W), .NB_W(NB_W)) u_txsh (
        .clk(clk), .rst_n(rst_n), .load(accept), .data(tx_data),
        .nbits(nbits_sel), .msb(mode_sel.msb), .shift(shift_en), .bit_out(tx_bit)
    );

    spi_eng_rxsh #(.WORD_W(WORD_W), .NB_W(NB_W)) u_rxsh (
        .clk(clk), .rst_n(rst_n), .clear(accept), .sample(samp_en), .bit_in(rx_bit),
        .msb(mode_q.msb), .nbits(nbits_q), .word(rx_word)
    );
endmodule

// File: rtl/spi_eng_chk.sv
// Property checker for spi_eng_core, attached with bind.
// Watches the ports together with the captured settings and the tick.
module spi_eng_chk #(
    parameter int DIV_W  = 16,
    parameter int WORD_W = 32,
    parameter int NB_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic [WORD_W-1:0] rx_data,
    input logic              sclk,
    input logic              mosi,
    input logic              tick,
    input logic              rx_off_q,
    input logic              tx_off_q,
    input logic [NB_W-1:0]   nbits_q,
    input logic [DIV_W-1:0]  div_q
);
    AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$past(tick) |-> $stable(sclk)); // R1
    AST_RX_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> nbits_q) == '0)); // R2
    AST_TXOFF_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && tx_off_q && $past(busy) |-> $stable(mosi)); // R6
    AST_RXOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !rx_off_q); // R7
    AST_RX_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(busy)); // R8
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_ready); // R9
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && busy |=> busy); // R9
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(div_q) && $stable(nbits_q)); // R10
endmodule

bind spi_eng_core spi_eng_chk #(.DIV_W(DIV_W), .WORD_W(WORD_W), .NB_W(NB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .tick(tick),
    .rx_off_q(mode_q.rx_off), .tx_off_q(mode_q.tx_off), .nbits_q(nbits_q), .div_q(div_q)
);

// File: tb/spi_eng_core_tb_top.sv
// Bench for spi_eng_core: behavioural cycle model, compared every clock.
module spi_eng_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = '0;
    logic [4:0]  cfg_len_m1 = 5'd7;
    logic        cfg_pol = 0, cfg_ph = 1, cfg_idle = 0, cfg_msb = 1;
    logic        cfg_loop = 0, cfg_tx_off = 0, cfg_rx_off = 0;
    logic        tx_valid = 0;
    logic [31:0] tx_data = '0;
    logic        miso = 0;
    logic        tx_ready, rx_valid, sclk, mosi, busy;
    logic [31:0] rx_data;

    int n_chk = 0, n_fail = 0, cyc = 0, rxv_seen = 0;
    logic [31:0] stim_q[$];
    logic [31:0] last_rx;

    // Model state
    int  m_act = 0, m_t = 0, m_T = 2, m_B = 0, m_N = 8;
    bit  m_pol, m_ph, m_idle, m_msb, m_loop, m_txo, m_rxo;
    logic [31:0] m_word, m_rx, exp_rxd = '0;
    bit  exp_rxv = 0;

    always #4 clk = ~clk;

    spi_eng_core dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len_m1(cfg_len_m1),
        .cfg_pol(cfg_pol), .cfg_ph(cfg_ph), .cfg_idle(cfg_idle), .cfg_msb(cfg_msb),
        .cfg_loop(cfg_loop), .cfg_tx_off(cfg_tx_off), .cfg_rx_off(cfg_rx_off),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
        .miso(miso), .busy(busy)
    );

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic bit exp_ready();
        return (m_act == 0) || (m_t == m_T - 1);
    endfunction

    function automatic bit exp_mosi();
        int h, k;
        if (m_act == 0) return cfg_idle;
        if (m_txo) return m_idle;
        h = m_t / (m_B + 1);
        k = m_ph ? h / 2 : ((h == 0) ? 0 : (h - 1) / 2);
        return m_msb ? m_word[m_N - 1 - k] : m_word[k];
    endfunction

    function automatic bit exp_sclk();
        if (m_act == 0) return cfg_pol;
        return m_pol ^ bit'((m_t / (m_B + 1)) % 2);
    endfunction

    // Reference model: advances once per clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; exp_rxv = 0; exp_rxd = '0;
        end else begin
            bit acc;
            acc = tx_valid && exp_ready();
            exp_rxv = 0;
            if (m_act != 0 && (m_t % (m_B + 1)) == m_B) begin
                int h;
                h = m_t / (m_B + 1);
                if (m_ph ? (h % 2 == 0) : (h % 2 == 1)) begin
                    int k;
                    k = m_ph ? h / 2 : (h - 1) / 2;
                    m_rx[m_msb ? (m_N - 1 - k) : k] = m_loop ? exp_mosi() : miso;
                end
            end
            if (m_act != 0 && m_t == m_T - 1 && !m_rxo) begin
                exp_rxv = 1; exp_rxd = m_rx;
            end
            if (acc) begin
                if (m_act == 0) begin
                    m_pol = cfg_pol; m_ph = cfg_ph; m_idle = cfg_idle; m_msb = cfg_msb;
                    m_loop = cfg_loop; m_txo = cfg_tx_off; m_rxo = cfg_rx_off;
                    m_B = int'(cfg_div);
                    m_N = (cfg_len_m1 == 0) ? 2 : int'(cfg_len_m1) + 1;
                end
                m_word = tx_data; m_rx = '0; m_act = 1; m_t = 0;
                m_T = 2 * m_N * (m_B + 1);
                void'(stim_q.pop_front());
            end else if (m_act != 0) begin
                if (m_t == m_T - 1) m_act = 0;
                else m_t++;
            end
        end
    end

    // Drive inputs at the falling edge, then compare every output.
    always @(negedge clk) begin
        cyc++;
        miso     <= 1'($urandom);
        tx_valid <= (stim_q.size() > 0);
        tx_data  <= (stim_q.size() > 0) ? stim_q[0] : 32'h0;
        #1;
        if (rst_n) begin
            string tg;
            check(busy == bit'(m_act != 0), "R8", "busy", busy, m_act != 0);
            check(tx_ready == exp_ready(), "R9", "tx_ready", tx_ready, exp_ready());
            tg = (m_act == 0) ? "R11" : (cfg_div != 16'(m_B)) ? "R10" : "R1";
            check(sclk == exp_sclk(), tg, "sclk", sclk, exp_sclk());
            tg = (m_act == 0) ? "R11" : m_txo ? "R6" : !m_ph ? "R3" : "R4";
            check(mosi == exp_mosi(), tg, "mosi", mosi, exp_mosi());
            check(rx_valid == exp_rxv, "R7", "rx_valid", rx_valid, exp_rxv);
            if (rx_valid) begin
                rxv_seen++;
                last_rx = rx_data;
                check(rx_data == exp_rxd, m_loop ? "R5" : "R2", "rx_data", rx_data, exp_rxd);
            end
        end
    end

    task automatic set_cfg(int dv, int lm1, bit po, bit ph, bit idl, bit msb,
                           bit lp, bit txo, bit rxo);
        @(negedge clk);
        cfg_div = 16'(dv); cfg_len_m1 = 5'(lm1); cfg_pol = po; cfg_ph = ph;
        cfg_idle = idl; cfg_msb = msb; cfg_loop = lp; cfg_tx_off = txo; cfg_rx_off = rxo;
    endtask

    task automatic send(int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) stim_q.push_back($urandom);
    endtask

    task automatic drain();
        do @(negedge clk); while (stim_q.size() > 0 || m_act != 0);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #2;
        // R12: outputs during reset settle to the idle state
        check(busy == 0, "R12", "busy in reset", busy, 0);
        check(rx_valid == 0, "R12", "rx_valid in reset", rx_valid, 0);
        check(tx_ready == 1, "R12", "tx_ready in reset", tx_ready, 1);
        check(rx_data == 0, "R12", "rx_data in reset", rx_data, 0);
        rst_n = 1;
        // R1 R3 R4: mode 0, MSB first, fastest clock, back-to-back (R9)
        set_cfg(0, 7, 0, 1, 0, 1, 0, 0, 0); send(3); drain();
        // R3 R4: trailing-edge sampling, LSB first, inverted polarity
        set_cfg(2, 7, 1, 0, 1, 0, 0, 0, 0); send(2); drain();
        // R2: 16 and 32 bit words
        set_cfg(1, 15, 0, 1, 0, 1, 0, 0, 0); send(2); drain();
        set_cfg(0, 31, 1, 0, 0, 0, 0, 0, 0); send(2); drain();
        // R2: length field 0 clamps to 2 bits; 2 and 4 bits
        set_cfg(0, 0, 0, 1, 0, 1, 0, 0, 0); send(2); drain();
        set_cfg(1, 1, 0, 0, 0, 0, 0, 0, 0); send(1); drain();
        set_cfg(0, 3, 1, 1, 1, 1, 0, 0, 0); send(2); drain();
        // R5: loopback returns the sent word
        set_cfg(1, 7, 0, 1, 0, 1, 1, 0, 0);
        @(negedge clk); stim_q.push_back(32'h0000_00A5); drain();
        check(last_rx == 32'hA5, "R5", "loopback word", last_rx, 32'hA5);
        // R6: transmitter off, idle level looped back as all ones
        set_cfg(0, 7, 0, 1, 1, 1, 1, 1, 0);
        @(negedge clk); stim_q.push_back(32'h0000_0012); drain();
        check(last_rx == 32'hFF, "R6", "tx off loop word", last_rx, 32'hFF);
        // R7: receiver off gives no strobe
        rxv_seen = 0;
        set_cfg(0, 7, 0, 1, 0, 1, 0, 0, 1); send(3); drain();
        check(rxv_seen == 0, "R7", "rx strobes with rx off", rxv_seen, 0);
        // R10: settings changed while busy do not affect chained words
        set_cfg(1, 5, 0, 1, 0, 1, 0, 0, 0); send(3);
        repeat (5) @(negedge clk);
        cfg_div = 16'd3; cfg_len_m1 = 5'd11; cfg_ph = 0; cfg_msb = 0; cfg_pol = 1;
        drain();
        // R11: idle levels follow live inputs
        set_cfg(0, 7, 1, 1, 1, 1, 0, 0, 0);
        repeat (2) @(negedge clk);
        #2;
        check(sclk == 1 && mosi == 1, "R11", "idle levels", {sclk, mosi}, 2'b11);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule